// File: doc/BRIEF.md
# Hardwired Instruction-Cycle Sequencer

This block is the hardwired control sequencer of a small single-accumulator processor. A 2-bit phase register records which part of the instruction cycle is running: fetch, indirect, execute or interrupt. A step counter walks through the fixed micro-operation schedule of that phase. On every clock the block decodes phase, step, opcode and a zero flag into a set of individual control strobes. These strobes steer the register transfers, the accumulator operations and the memory read and write lines.

The top level also holds the datapath registers (program counter, memory address register, memory buffer register, instruction register, accumulator) and a word-wide memory model. This makes the whole instruction cycle observable at the ports. A preload port fills the memory while reset is held. An interrupt request input, already qualified by its enable, is sampled when an execute phase ends.

Instructions are 16 bits wide: opcode in bits 15:12, indirect flag in bit 11, address in bits 10:0. The instruction length is one word. Step numbers on the `step_o` port count from 0, so "step 2" in a schedule below shows as 1.

Top module: `instr_cycle_ctl`

## Requirements
- R1: While reset is low and at the first clock after its release, the program counter and accumulator are 0, `phase_o` is 00 (fetch) and `step_o` is 0.
- R2: The phase codes are 00 fetch, 01 indirect, 10 execute and 11 interrupt. Fetch is followed by indirect when bit 11 of the fetched word is 1 and by execute otherwise. Indirect is always followed by execute. Execute is followed by interrupt when `irq_pend` is 1 in its last step and by fetch otherwise. Interrupt is always followed by fetch.
- R3: Fetch takes three steps. Step 1 loads the address register from the program counter. Step 2 reads memory into the buffer register and adds 1 to the program counter. Step 3 copies the buffer register into the instruction register.
- R4: Indirect takes three steps. Step 1 loads the address register from IR[10:0]. Step 2 reads memory. Step 3 replaces IR[10:0] with the buffer's bits 10:0 and leaves IR[15:11] unchanged.
- R5: Interrupt takes three steps. Step 1 copies the program counter into the buffer register. Step 2 loads the address register with SAVE_ADDR and the program counter with ROUTINE_ADDR. Step 3 writes the zero-extended return address to memory at SAVE_ADDR.
- R6: Opcode 6 (increment and skip if zero) takes four execute steps. It reads M[X], increments the value, and writes it back in step 4. In that same step the program counter advances by one more when the written value is 0.
- R7: Opcode 5 (branch and save address) takes three execute steps. It writes the zero-extended address of the next instruction to M[X] and then continues at X+1.
- R8: The other opcodes are as follows. Opcodes 0 (AND), 1 (add, modulo 2^16) and 2 (load) each take three steps and leave their result in the accumulator. Opcode 3 (store) takes two steps and writes the accumulator to M[X]. Opcode 4 (jump) takes one step and sets the program counter to X. Opcode 7 takes one step and complements the accumulator. Opcodes 8 to 15 take one step and change nothing.
- R9: `mem_rd_o` is high only in step 2 of fetch, of indirect, and of execute for opcodes 0, 1, 2 and 6. `mem_wr_o` is high only in step 2 of opcodes 3 and 5, step 4 of opcode 6 and step 3 of interrupt. The two are never high together. A write stores `mbr_o` at `mar_o`.
- R10: Within a phase the step counter advances by one per clock. After the last step of a phase it returns to 0. An instruction cycle therefore lasts 3 + 3·(indirect) + execute steps + 3·(interrupt taken) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pend | input | 1 | Enabled interrupt request, sampled at the end of execute |
| pre_we | input | 1 | Memory preload write enable, used while reset is low |
| pre_addr | input | 11 | Memory preload address |
| pre_data | input | 16 | Memory preload data |
| phase_o | output | 2 | Current phase code |
| step_o | output | 2 | Current step within the phase, from 0 |
| pc_o | output | 11 | Program counter |
| ac_o | output | 16 | Accumulator |
| ir_o | output | 16 | Instruction register |
| mar_o | output | 11 | Memory address register |
| mbr_o | output | 16 | Memory buffer register |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |

## Verification
The hardest case to reach is an interrupt that lands on an instruction that has already used the indirect phase and the increment-and-skip path whose incremented value wraps to zero. That instruction cycle has the longest phase chain and two memory writes. Random memory images are used, in which about one word in sixteen is all ones and a third of the instructions are indirect, with the interrupt request raised on a random sixth of instructions. A directed program forces the wrap-to-zero skip, an indirect increment, a call and return through an indirect jump, and an interrupt on a no-op.

// File: rtl/cuc_pkg.sv
package cuc_pkg;

  localparam int OP_W    = 4;
  localparam int ADDR_W  = 11;
  localparam int WORD_W  = OP_W + 1 + ADDR_W;
  localparam int IND_BIT = ADDR_W;
  localparam int STEP_W  = 2;

  typedef logic [OP_W-1:0]   opcode_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [STEP_W-1:0] step_t;

  typedef enum logic [1:0] {
    PH_FETCH = 2'b00,
    PH_IND   = 2'b01,
    PH_EXEC  = 2'b10,
    PH_INTR  = 2'b11
  } phase_e;

  localparam opcode_t OP_AND = opcode_t'(0);
  localparam opcode_t OP_ADD = opcode_t'(1);
  localparam opcode_t OP_LDA = opcode_t'(2);
  localparam opcode_t OP_STA = opcode_t'(3);
  localparam opcode_t OP_JMP = opcode_t'(4);
  localparam opcode_t OP_BSA = opcode_t'(5);
  localparam opcode_t OP_ISZ = opcode_t'(6);
  localparam opcode_t OP_CMA = opcode_t'(7);

  // One strobe per register source or operation.
  typedef struct packed {
    logic mar_pc;
    logic mar_ir;
    logic mar_save;
    logic mbr_mem;
    logic mbr_pc;
    logic mbr_ac;
    logic mbr_inc;
    logic ir_mbr;
    logic ir_addr;
    logic pc_inc;
    logic pc_ir;
    logic pc_rtn;
    logic ac_mbr;
    logic ac_add;
    logic ac_and;
    logic ac_not;
    logic mem_rd;
    logic mem_wr;
  } ctl_t;

  function automatic word_t word_add(input word_t a, input word_t b);
    return a + b;
  endfunction

  function automatic word_t word_inc(input word_t a);
    return a + word_t'(1);
  endfunction

  function automatic addr_t addr_inc(input addr_t a);
    return a + addr_t'(1);
  endfunction

  // Index of the final step of a phase.
  function automatic step_t step_last(input phase_e ph, input opcode_t op);
    step_t s;
    s = step_t'(2);
    if (ph == PH_EXEC) begin
      case (op)
        OP_AND, OP_ADD, OP_LDA, OP_BSA: s = step_t'(2);
        OP_STA:                         s = step_t'(1);
        OP_ISZ:                         s = step_t'(3);
        default:                        s = step_t'(0);
      endcase
    end
    return s;
  endfunction

  function automatic phase_e phase_after(input phase_e ph, input logic ind,
                                         input logic irq);
    phase_e n;
    case (ph)
      PH_FETCH: n = ind ? PH_IND : PH_EXEC;
      PH_IND:   n = PH_EXEC;
      PH_EXEC:  n = irq ? PH_INTR : PH_FETCH;
      default:  n = PH_FETCH;
    endcase
    return n;
  endfunction

  // Micro-operation schedule: phase, step, opcode -> strobes.
  function automatic ctl_t schedule(input phase_e ph, input step_t st,
                                    input opcode_t op, input logic zero);
    ctl_t c;
    c = '0;
    case (ph)
      PH_FETCH: begin
        case (st)
          2'd0: c.mar_pc = 1'b1;
          2'd1: begin c.mbr_mem = 1'b1; c.mem_rd = 1'b1; c.pc_inc = 1'b1; end
          2'd2: c.ir_mbr = 1'b1;
          default: ;
        endcase
      end
      PH_IND: begin
        case (st)
          2'd0: c.mar_ir = 1'b1;
          2'd1: begin c.mbr_mem = 1'b1; c.mem_rd = 1'b1; end
          2'd2: c.ir_addr = 1'b1;
          default: ;
        endcase
      end
      PH_INTR: begin
        case (st)
          2'd0: c.mbr_pc = 1'b1;
          2'd1: begin c.mar_save = 1'b1; c.pc_rtn = 1'b1; end
          2'd2: c.mem_wr = 1'b1;
          default: ;
        endcase
      end
      default: begin
        case (op)
          OP_AND, OP_ADD, OP_LDA: begin
            case (st)
              2'd0: c.mar_ir = 1'b1;
              2'd1: begin c.mbr_mem = 1'b1; c.mem_rd = 1'b1; end
              2'd2: begin
                c.ac_and = (op == OP_AND);
                c.ac_add = (op == OP_ADD);
                c.ac_mbr = (op == OP_LDA);
              end
              default: ;
            endcase
          end
          OP_STA: begin
            case (st)
              2'd0: begin c.mar_ir = 1'b1; c.mbr_ac = 1'b1; end
              2'd1: c.mem_wr = 1'b1;
              default: ;
            endcase
          end
          OP_JMP: c.pc_ir = (st == 2'd0);
          OP_BSA: begin
            case (st)
              2'd0: begin c.mar_ir = 1'b1; c.mbr_pc = 1'b1; end
              2'd1: begin c.pc_ir = 1'b1; c.mem_wr = 1'b1; end
              2'd2: c.pc_inc = 1'b1;
              default: ;
            endcase
          end
          OP_ISZ: begin
            case (st)
              2'd0: c.mar_ir = 1'b1;
              2'd1: begin c.mbr_mem = 1'b1; c.mem_rd = 1'b1; end
              2'd2: c.mbr_inc = 1'b1;
              default: begin c.mem_wr = 1'b1; c.pc_inc = zero; end
            endcase
          end
          OP_CMA: c.ac_not = (st == 2'd0);
          default: ;
        endcase
      end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/cuc_sequencer.sv
module cuc_sequencer
  import cuc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  opcode_t opcode,
  input  logic    fetched_ind,
  input  logic    zero,
  input  logic    irq,
  output phase_e  phase,
  output step_t   step,
  output ctl_t    ctl,
  output logic    phase_done
);

  always_comb begin
    phase_done = (step == step_last(phase, opcode));
    ctl        = schedule(phase, step, opcode, zero);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_FETCH;
      step  <= '0;
    end else if (phase_done) begin
      phase <= phase_after(phase, fetched_ind, irq);
      step  <= '0;
    end else begin
      step  <= step + step_t'(1);
    end
  end

endmodule

// File: rtl/cuc_datapath.sv
module cuc_datapath
  import cuc_pkg::*;
#(
  parameter addr_t SAVE_ADDR    = addr_t'(11'h7F0),
  parameter addr_t ROUTINE_ADDR = addr_t'(11'h7E0)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  ctl_t  ctl,
  input  word_t rdata,
  output addr_t pc,
  output addr_t mar,
  output word_t mbr,
  output word_t ir,
  output word_t ac,
  output logic  zero,
  output logic  bus_rd,
  output logic  bus_wr
);

  addr_t ir_field;
  assign ir_field = ir[ADDR_W-1:0];
  assign zero     = (mbr == '0);
  assign bus_rd   = ctl.mem_rd;
  assign bus_wr   = ctl.mem_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc  <= '0;
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
      ac  <= '0;
    end else begin
      if (ctl.mar_pc)        mar <= pc;
      else if (ctl.mar_ir)   mar <= ir_field;
      else if (ctl.mar_save) mar <= SAVE_ADDR;

      if (ctl.mbr_mem)       mbr <= rdata;
      else if (ctl.mbr_pc)   mbr <= word_t'(pc);
      else if (ctl.mbr_ac)   mbr <= ac;
      else if (ctl.mbr_inc)  mbr <= word_inc(mbr);

      if (ctl.ir_mbr)        ir <= mbr;
      else if (ctl.ir_addr)  ir <= {ir[WORD_W-1:ADDR_W], mbr[ADDR_W-1:0]};

      if (ctl.pc_inc)        pc <= addr_inc(pc);
      else if (ctl.pc_ir)    pc <= ir_field;
      else if (ctl.pc_rtn)   pc <= ROUTINE_ADDR;

      if (ctl.ac_mbr)        ac <= mbr;
      else if (ctl.ac_add)   ac <= word_add(ac, mbr);
      else if (ctl.ac_and)   ac <= ac & mbr;
      else if (ctl.ac_not)   ac <= ~ac;
    end
  end

endmodule

// File: rtl/cuc_memory.sv
module cuc_memory #(
  parameter int AW = 11,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/instr_cycle_ctl.sv
module instr_cycle_ctl
  import cuc_pkg::*;
#(
  parameter addr_t SAVE_ADDR    = addr_t'(11'h7F0),
  parameter addr_t ROUTINE_ADDR = addr_t'(11'h7E0)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_pend,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [WORD_W-1:0] pre_data,
  output logic [1:0]        phase_o,
  output logic [STEP_W-1:0] step_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [WORD_W-1:0] ac_o,
  output logic [WORD_W-1:0] ir_o,
  output logic [ADDR_W-1:0] mar_o,
  output logic [WORD_W-1:0] mbr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o
);

  phase_e  phase_q;
  step_t   step_q;
  ctl_t    ctl;
  logic    phase_done;
  addr_t   pc, mar;
  word_t   mbr, ir, ac, rdata;
  logic    zero, bus_rd, bus_wr;
  opcode_t opcode;
  logic    fetched_ind;

  // Named internal events for the checker.
  logic [2:0] mar_src;
  logic [2:0] pc_src;

  logic  mem_we;
  addr_t mem_waddr;
  word_t mem_wdata;

  assign opcode      = ir[WORD_W-1 -: OP_W];
  assign fetched_ind = mbr[IND_BIT];
  assign mar_src     = {ctl.mar_pc, ctl.mar_ir, ctl.mar_save};
  assign pc_src      = {ctl.pc_inc, ctl.pc_ir, ctl.pc_rtn};

  cuc_sequencer seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .opcode      (opcode),
    .fetched_ind (fetched_ind),
    .zero        (zero),
    .irq         (irq_pend),
    .phase       (phase_q),
    .step        (step_q),
    .ctl         (ctl),
    .phase_done  (phase_done)
  );

  cuc_datapath #(
    .SAVE_ADDR    (SAVE_ADDR),
    .ROUTINE_ADDR (ROUTINE_ADDR)
  ) dp_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl    (ctl),
    .rdata  (rdata),
    .pc     (pc),
    .mar    (mar),
    .mbr    (mbr),
    .ir     (ir),
    .ac     (ac),
    .zero   (zero),
    .bus_rd (bus_rd),
    .bus_wr (bus_wr)
  );

  assign mem_we    = pre_we | bus_wr;
  assign mem_waddr = pre_we ? pre_addr : mar;
  assign mem_wdata = pre_we ? pre_data : mbr;

  cuc_memory #(
    .AW (ADDR_W),
    .DW (WORD_W)
  ) mem_i (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mar),
    .rdata (rdata)
  );

  assign phase_o  = phase_q;
  assign step_o   = step_q;
  assign pc_o     = pc;
  assign ac_o     = ac;
  assign ir_o     = ir;
  assign mar_o    = mar;
  assign mbr_o    = mbr;
  assign mem_rd_o = bus_rd;
  assign mem_wr_o = bus_wr;

endmodule

// File: rtl/cuc_checker.sv
module cuc_checker #(
  parameter int AW = 11,
  parameter logic [AW-1:0] RTN = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    phase,
  input logic [1:0]    step,
  input logic          phase_done,
  input logic          irq,
  input logic          fetched_ind,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [2:0]    mar_src,
  input logic [2:0]    pc_src,
  input logic [AW-1:0] pc
);

  p_fetch_to_ind_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b00 && phase_done && fetched_ind) |=> phase == 2'b01);

  p_ind_to_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b01 && phase_done) |=> phase == 2'b10);

  p_exec_to_intr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b10 && phase_done && irq) |=> phase == 2'b11);

  p_intr_to_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b11 && phase_done) |=> phase == 2'b00);

  p_fetch_pc_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b00 && step == 2'd1) |=> pc == $past(pc) + AW'(1));

  p_mar_one_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mar_src));

  p_pc_one_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pc_src));

  p_intr_vector_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b11 && step == 2'd1) |=> pc == RTN);

  p_rw_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_rd_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (step == 2'd1 && phase != 2'b11));

  p_wr_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> phase[1]);

  p_step_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    phase_done |=> step == 2'd0);

  p_step_adv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_done |=> (step == 2'($past(step) + 2'd1) && $stable(phase)));

endmodule

bind instr_cycle_ctl cuc_checker #(
  .AW  (ADDR_W),
  .RTN (ROUTINE_ADDR)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .phase       (phase_q),
  .step        (step_q),
  .phase_done  (phase_done),
  .irq         (irq_pend),
  .fetched_ind (fetched_ind),
  .mem_rd      (bus_rd),
  .mem_wr      (bus_wr),
  .mar_src     (mar_src),
  .pc_src      (pc_src),
  .pc          (pc)
);

// File: tb/instr_cycle_ctl_tb_top.sv
module instr_cycle_ctl_tb_top;

  localparam int AW = 11;
  localparam int DW = 16;
  localparam logic [AW-1:0] SAVE = 11'h7F0;
  localparam logic [AW-1:0] RTN  = 11'h7E0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq = 1'b0;
  logic pre_we = 1'b0;
  logic [AW-1:0] pre_addr = '0;
  logic [DW-1:0] pre_data = '0;
  logic [1:0] phase_o, step_o;
  logic [AW-1:0] pc_o, mar_o;
  logic [DW-1:0] ac_o, ir_o, mbr_o;
  logic mem_rd_o, mem_wr_o;

  always #4 clk = ~clk;

  instr_cycle_ctl #(.SAVE_ADDR(SAVE), .ROUTINE_ADDR(RTN)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_pend(irq), .pre_we(pre_we),
    .pre_addr(pre_addr), .pre_data(pre_data), .phase_o(phase_o),
    .step_o(step_o), .pc_o(pc_o), .ac_o(ac_o), .ir_o(ir_o), .mar_o(mar_o),
    .mbr_o(mbr_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] ref_mem [1 << AW];
  logic [AW-1:0] m_pc;
  logic [DW-1:0] m_ac;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int exec_len(input logic [3:0] op);
    case (op)
      4'd0, 4'd1, 4'd2, 4'd5: return 3;
      4'd3:                   return 2;
      4'd6:                   return 4;
      default:                return 1;
    endcase
  endfunction

  function automatic logic [DW-1:0] directed_word(input int i);
    case (i)
      0:    return 16'h2040;  // load 040
      1:    return 16'h1041;  // add 041
      2:    return 16'h0042;  // and 042
      3:    return 16'h7000;  // complement
      4:    return 16'h3043;  // store 043
      5:    return 16'h6044;  // isz 044, wraps to 0 -> skip
      6:    return 16'h7000;  // skipped
      7:    return 16'h6845;  // isz indirect via 045
      8:    return 16'h5050;  // call 050
      9:    return 16'h1845;  // add indirect via 045
      10:   return 16'h2044;  // load 044
      11:   return 16'hF000;  // no-op
      12:   return 16'h4000;  // jump 000
      'h40: return 16'h1234;
      'h41: return 16'h0101;
      'h42: return 16'hFF0F;
      'h44: return 16'hFFFF;
      'h45: return 16'h0046;
      'h46: return 16'h0005;
      'h51: return 16'h4850;  // return through indirect jump
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [DW-1:0] random_word();
    if ($urandom % 16 == 0) return 16'hFFFF;
    return {4'($urandom % 10), 1'($urandom % 3 == 0), 11'($urandom)};
  endfunction

  task automatic load_and_reset(input bit directed);
    rst_n = 1'b0;
    irq = 1'b0;
    for (int i = 0; i < (1 << AW); i++) begin
      pre_we = 1'b1;
      pre_addr = AW'(i);
      pre_data = directed ? directed_word(i) : random_word();
      ref_mem[i] = pre_data;
      @(negedge clk);
    end
    pre_we = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(pc_o == '0, "R1", "pc after reset", pc_o, 0);
    chk(ac_o == '0, "R1", "ac after reset", ac_o, 0);
    chk(phase_o == 2'b00 && step_o == 2'd0, "R1", "phase/step after reset",
        {phase_o, step_o}, 0);
    rst_n = 1'b1;
    m_pc = '0;
    m_ac = '0;
    chk(phase_o == 2'b00 && step_o == 2'd0, "R1", "phase/step at release",
        {phase_o, step_o}, 0);
  endtask

  task automatic run_instr(input bit irqv);
    logic [DW-1:0] w, v, m_ir;
    logic [3:0] op;
    bit ind;
    logic [AW-1:0] a;
    logic [AW-1:0] ewa [2];
    logic [DW-1:0] ewd [2];
    logic [AW-1:0] owa [2];
    logic [DW-1:0] owd [2];
    int cyc, rd, wr, ew, ow, saw_ind, saw_int, exp_cyc, exp_rd;
    string ptag, otag;
    cyc = 0; rd = 0; wr = 0; ew = 0; ow = 0; saw_ind = 0; saw_int = 0;
    irq = irqv;
    // reference model of one instruction cycle
    w = ref_mem[m_pc];
    m_pc = m_pc + 1'b1;
    op = w[15:12];
    ind = w[11];
    a = w[10:0];
    if (ind) a = ref_mem[a][10:0];
    m_ir = {w[15:11], a};
    case (op)
      4'd0: m_ac = m_ac & ref_mem[a];
      4'd1: m_ac = m_ac + ref_mem[a];
      4'd2: m_ac = ref_mem[a];
      4'd3: begin ref_mem[a] = m_ac; ewa[ew] = a; ewd[ew] = m_ac; ew++; end
      4'd4: m_pc = a;
      4'd5: begin
        ref_mem[a] = {5'd0, m_pc}; ewa[ew] = a; ewd[ew] = {5'd0, m_pc}; ew++;
        m_pc = a + 1'b1;
      end
      4'd6: begin
        v = ref_mem[a] + 1'b1;
        ref_mem[a] = v; ewa[ew] = a; ewd[ew] = v; ew++;
        if (v == '0) m_pc = m_pc + 1'b1;
      end
      4'd7: m_ac = ~m_ac;
      default: ;
    endcase
    if (irqv) begin
      ref_mem[SAVE] = {5'd0, m_pc}; ewa[ew] = SAVE; ewd[ew] = {5'd0, m_pc}; ew++;
      m_pc = RTN;
    end
    otag = (op == 4'd6) ? "R6" : (op == 4'd5) ? "R7" : "R8";
    ptag = irqv ? "R5" : (op == 4'd6 || op == 4'd5 || op == 4'd4) ? otag : "R3";
    // observe the design until the next fetch step 0
    do begin
      rd += int'(mem_rd_o);
      wr += int'(mem_wr_o);
      if (mem_wr_o && ow < 2) begin owa[ow] = mar_o; owd[ow] = mbr_o; ow++; end
      if (phase_o == 2'b01 && step_o == 2'd0) saw_ind++;
      if (phase_o == 2'b11 && step_o == 2'd0) saw_int++;
      @(negedge clk);
      cyc++;
    end while (!(phase_o == 2'b00 && step_o == 2'd0) && cyc < 40);
    exp_cyc = 3 + (ind ? 3 : 0) + exec_len(op) + (irqv ? 3 : 0);
    exp_rd = 1 + int'(ind) + ((op <= 4'd2 || op == 4'd6) ? 1 : 0);
    chk(cyc == exp_cyc, "R10", "cycle length", cyc, exp_cyc);
    chk(saw_ind == int'(ind) && saw_int == int'(irqv), "R2", "phase sequence",
        saw_ind * 16 + saw_int, int'(ind) * 16 + int'(irqv));
    chk(pc_o == m_pc, ptag, "pc", pc_o, m_pc);
    chk(ac_o == m_ac, "R8", "ac", ac_o, m_ac);
    chk(ir_o == m_ir, ind ? "R4" : "R3", "ir", ir_o, m_ir);
    chk(rd == exp_rd, "R9", "read strobes", rd, exp_rd);
    chk(wr == ew, "R9", "write strobes", wr, ew);
    for (int i = 0; i < ew && i < ow; i++) begin
      chk(owa[i] == ewa[i] && owd[i] == ewd[i],
          (irqv && i == ew - 1) ? "R5" : otag, "write addr/data",
          {owa[i], owd[i]}, {ewa[i], ewd[i]});
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    // directed program: skip on wrap, indirect isz, call/return, irq on no-op
    load_and_reset(1'b1);
    for (int k = 0; k < 16; k++) run_instr(k == 11);
    // random memory images
    for (int r = 0; r < 2; r++) begin
      load_and_reset(1'b0);
      for (int k = 0; k < 400; k++) run_instr($urandom % 6 == 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule